// File: doc/BRIEF.md
# Display PLL Post-Divider Clock Tree

This block turns the fast clock of a display PLL into the two rates a serial display link consumes: a byte rate for the lane serializers and a pixel rate for the video pipeline. A power-of-two output divider sits first in the chain and feeds a programmable bit-rate divider. A fixed divide-by-8 stage after it gives the byte rate. The pixel path uses a four-way selector, which picks one of four intermediate rates, and a programmable pixel divider after it.

Every stage is a counter that produces clock-enable pulses in the VCO clock domain, so the whole tree runs on one clock. Each output is a one-cycle enable pulse that a consumer uses to qualify its flops. Configuration comes from three register-style words. The caller writes them at any time, and the block takes each change at a point where it can cause no short pulse. A source field makes the tree count either every VCO cycle or only the cycles marked by an external-source tick. A global enable bit silences both outputs.

Top module: `clk_postdiv_tree`

## Requirements
- R1: Bits 1:0 of `cfg_outdiv` hold an exponent E. The output-divider rate is one pulse every 2^E source ticks.
- R2: Bits 3:0 of `cfg_word0` hold the bit-rate divisor N. It is one-based: value N divides the output-divider rate by N, and value 0 divides by 1.
- R3: `byte_en` pulses once every 8 bit-rate ticks, so two byte pulses are always at least 8 cycles apart.
- R4: Bits 1:0 of `cfg_word1` choose the pixel tap. 0 selects the bit rate, 1 the bit rate halved, 2 the output-divider rate, and 3 the output-divider rate divided by 4.
- R5: Bits 7:4 of `cfg_word0` hold the pixel divisor M. It is one-based like R2 (0 divides by 1) and divides the chosen tap.
- R6: Bit 5 of `cfg_word1` is a global enable. While it is 0, `byte_en` and `pix_en` stay low. When it is set again, the pulses resume at the configured periods.
- R7: Bits 3:2 of `cfg_word1` pick the source. Value 1 makes the whole tree advance only on cycles where `ext_tick` is high. Values 0, 2 and 3 make it advance on every clock cycle.
- R8: A new divisor takes effect only when that divider reaches its terminal count. While a divisor changes, no output interval is shorter than the smaller of the old and new periods.
- R9: A new tap choice is applied only in a cycle where none of the four taps pulses. If the output-divider tap pulses every cycle, the previous choice is kept.
- R10: Each output is a registered one-cycle pulse, one cycle after the tick that causes it. Both outputs are low while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO clock; all logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick | input | 1 | Advance marker used when the external source is chosen |
| cfg_outdiv | input | 8 | Output-divider word; bits 1:0 are the exponent |
| cfg_word0 | input | 8 | Bit divisor in 3:0, pixel divisor in 7:4 |
| cfg_word1 | input | 8 | Tap select 1:0, source 3:2, global enable 5 |
| byte_en | output | 1 | Byte-rate enable pulse |
| pix_en | output | 1 | Pixel-rate enable pulse |

## Verification
A wrong counter limit or a wrong encoding shows up as a wrong spacing between output pulses. This is visible within one output period after the configuration settles, which is at most a few hundred cycles. A tap or divisor that is reloaded at the wrong moment shows up as one interval shorter than both the old and new periods during the change, or as a selector that moves while the output-divider tap pulses every cycle. A broken enable or source path appears as pulses that are present when they must be absent, or as periods that do not scale with the external tick spacing.

// File: rtl/postdiv_pkg.sv
`timescale 1ns/1ps
package postdiv_pkg;

    localparam int PD_CNT_W = 4;

    localparam logic [1:0] SRC_EXTERNAL = 2'd1;

    typedef enum logic [1:0] {
        TAP_BIT     = 2'd0,
        TAP_BIT_HALF = 2'd1,
        TAP_OUT     = 2'd2,
        TAP_OUT_QTR = 2'd3
    } tap_sel_e;

    typedef struct packed {
        logic [3:0] pix_n;
        logic [3:0] bit_n;
    } word0_t;

    typedef struct packed {
        logic [1:0] rsv_hi;
        logic       glob_en;
        logic       rsv_mid;
        logic [1:0] src;
        tap_sel_e   tap;
    } word1_t;

    function automatic logic [PD_CNT_W-1:0] one_based(input logic [3:0] fld);
        return (fld == 4'd0) ? PD_CNT_W'(1) : PD_CNT_W'(fld);
    endfunction

    function automatic logic [PD_CNT_W-1:0] pow2_div(input logic [1:0] ex);
        return PD_CNT_W'(1) << ex;
    endfunction

endpackage

// File: rtl/postdiv_tick_div.sv
`timescale 1ns/1ps
module postdiv_tick_div #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_tick,
    input  logic [W-1:0] div_req,
    output logic         out_tick
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] lim_q;
    logic [W-1:0] req_lim;
    logic         term;

    assign req_lim  = (div_req == '0) ? '0 : div_req - W'(1);
    assign term     = (cnt_q >= lim_q);
    assign out_tick = in_tick & term;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= req_lim;
        end else if (in_tick) begin
            if (term) begin
                cnt_q <= '0;
                lim_q <= req_lim;
            end else begin
                cnt_q <= cnt_q + W'(1);
            end
        end
    end
endmodule

// File: rtl/clk_postdiv_tree.sv
`timescale 1ns/1ps
module clk_postdiv_tree
    import postdiv_pkg::*;
#(
    parameter int CNT_W         = PD_CNT_W,
    parameter int BYTE_RATIO    = 8,
    parameter int HALF_RATIO    = 2,
    parameter int QUARTER_RATIO = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_tick,
    input  logic [7:0] cfg_outdiv,
    input  logic [7:0] cfg_word0,
    input  logic [7:0] cfg_word1,
    output logic       byte_en,
    output logic       pix_en
);
    localparam int NTAP = 4;

    word0_t w0;
    word1_t w1;
    assign w0 = word0_t'(cfg_word0);
    assign w1 = word1_t'(cfg_word1);

    logic unused_cfg;
    assign unused_cfg = ^{cfg_outdiv[7:2], w1.rsv_hi, w1.rsv_mid};

    logic src_tick, od_tick, bit_tick, byte_tick;
    logic half_tick, qtr_tick, mux_tick, pix_tick;
    logic [NTAP-1:0] taps;
    tap_sel_e sel_q;

    // source: external marker or every cycle
    assign src_tick = (w1.src == SRC_EXTERNAL) ? ext_tick : 1'b1;

    postdiv_tick_div #(.W(CNT_W)) u_outdiv (
        .clk(clk), .rst(rst), .in_tick(src_tick),
        .div_req(CNT_W'(pow2_div(cfg_outdiv[1:0]))), .out_tick(od_tick));

    postdiv_tick_div #(.W(CNT_W)) u_bitdiv (
        .clk(clk), .rst(rst), .in_tick(od_tick),
        .div_req(CNT_W'(one_based(w0.bit_n))), .out_tick(bit_tick));

    postdiv_tick_div #(.W(CNT_W)) u_bytediv (
        .clk(clk), .rst(rst), .in_tick(bit_tick),
        .div_req(CNT_W'(BYTE_RATIO)), .out_tick(byte_tick));

    postdiv_tick_div #(.W(CNT_W)) u_halfdiv (
        .clk(clk), .rst(rst), .in_tick(bit_tick),
        .div_req(CNT_W'(HALF_RATIO)), .out_tick(half_tick));

    postdiv_tick_div #(.W(CNT_W)) u_qtrdiv (
        .clk(clk), .rst(rst), .in_tick(od_tick),
        .div_req(CNT_W'(QUARTER_RATIO)), .out_tick(qtr_tick));

    // tap index order follows the selector encoding
    assign taps = {qtr_tick, od_tick, half_tick, bit_tick};

    // selector moves only in a quiet cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= w1.tap;
        end else if (taps == '0) begin
            sel_q <= w1.tap;
        end
    end

    assign mux_tick = taps[sel_q];

    postdiv_tick_div #(.W(CNT_W)) u_pixdiv (
        .clk(clk), .rst(rst), .in_tick(mux_tick),
        .div_req(CNT_W'(one_based(w0.pix_n))), .out_tick(pix_tick));

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_en <= 1'b0;
            pix_en  <= 1'b0;
        end else begin
            byte_en <= byte_tick & w1.glob_en;
            pix_en  <= pix_tick & w1.glob_en;
        end
    end
endmodule

// File: rtl/clk_postdiv_tree_chk.sv
`timescale 1ns/1ps
module clk_postdiv_tree_chk #(
    parameter int BYTE_RATIO = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       glob_en,
    input logic       byte_en,
    input logic       pix_en,
    input logic [1:0] sel_q,
    input logic [3:0] taps
);
    logic [7:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || byte_en) begin
            gap_q <= '0;
        end else if (gap_q != 8'hFF) begin
            gap_q <= gap_q + 8'd1;
        end
    end

    // R6: a cleared enable silences both outputs on the next cycle
    assert_gate_off_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(glob_en) |-> (!byte_en && !pix_en));

    // R9: the tap choice moves only after a cycle with no tap pulse
    assert_sel_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (sel_q != $past(sel_q))) |-> ($past(taps) == 4'd0));

    // R3: byte pulses are spaced by at least the byte ratio
    assert_byte_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        byte_en |-> (gap_q >= 8'(BYTE_RATIO - 1)));
endmodule

module postdiv_div_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         in_tick,
    input logic         out_tick,
    input logic [W-1:0] lim_q
);
    // R8: a divider limit reloads only at its terminal count
    assert_reload_at_term_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (lim_q != $past(lim_q))) |-> $past(out_tick));

    // R10: a divided pulse needs an input pulse in the same cycle
    assert_out_needs_in_R10: assert property (@(posedge clk) disable iff (rst)
        out_tick |-> in_tick);
endmodule

bind clk_postdiv_tree clk_postdiv_tree_chk #(.BYTE_RATIO(BYTE_RATIO)) u_chk (
    .clk(clk), .rst(rst), .glob_en(cfg_word1[5]),
    .byte_en(byte_en), .pix_en(pix_en), .sel_q(sel_q), .taps(taps));

bind postdiv_tick_div postdiv_div_chk #(.W(W)) u_div_chk (
    .clk(clk), .rst(rst), .in_tick(in_tick), .out_tick(out_tick), .lim_q(lim_q));

// File: tb/clk_postdiv_tree_bench.sv
`timescale 1ns/1ps
module clk_postdiv_tree_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_tick = 1'b0;
    logic [7:0] cfg_outdiv = 8'd0;
    logic [7:0] cfg_word0 = 8'h11;
    logic [7:0] cfg_word1 = 8'h22;
    logic       byte_en, pix_en;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int ext_period = 3;
    int ext_cnt = 0;
    int last_b = -1, last_p = -1;
    int min_b = 1 << 30, min_p = 1 << 30;
    bit done = 1'b0;

    int    exp_b[$], exp_p[$];
    string req_b[$], req_p[$];

    always #2.5 clk = ~clk;

    clk_postdiv_tree u_clk_postdiv_tree (
        .clk(clk), .rst(rst), .ext_tick(ext_tick),
        .cfg_outdiv(cfg_outdiv), .cfg_word0(cfg_word0), .cfg_word1(cfg_word1),
        .byte_en(byte_en), .pix_en(pix_en));

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        ext_cnt  = (ext_cnt + 1) % ext_period;
        ext_tick = (ext_cnt == 0);
    end

    task automatic check_eq(string req, string what, int act, int expv);
        compared++;
        if (act != expv) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic check_ge(string req, string what, int act, int bound);
        compared++;
        if (act < bound) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected>=%0d", req, what, act, bound);
        end
    endtask

    // monitor: measures pulse intervals and pops expected items
    always @(negedge clk) begin
        if (byte_en) begin
            if (last_b >= 0) begin
                if (cyc - last_b < min_b) min_b = cyc - last_b;
                if (exp_b.size() > 0)
                    check_eq(req_b.pop_front(), "byte period", cyc - last_b, exp_b.pop_front());
            end
            last_b = cyc;
        end
        if (pix_en) begin
            if (last_p >= 0) begin
                if (cyc - last_p < min_p) min_p = cyc - last_p;
                if (exp_p.size() > 0)
                    check_eq(req_p.pop_front(), "pixel period", cyc - last_p, exp_p.pop_front());
            end
            last_p = cyc;
        end
    end

    task automatic apply_cfg(int od, int n, int sel, int m, int src, bit en);
        @(negedge clk);
        cfg_outdiv = 8'(od);
        cfg_word0  = {4'(m), 4'(n)};
        cfg_word1  = {2'b00, en, 1'b0, 2'(src), 2'(sel)};
    endtask

    // driver: computes periods from the requirements and queues them
    task automatic run_case(int od, int n, int sel, int m, int src,
                            string rb, string rp, int eff_sel);
        int ns, ms, odp, bitp, tap, scale, guard;
        apply_cfg(od, n, sel, m, src, 1'b1);
        repeat (1500) @(negedge clk);
        ns = (n == 0) ? 1 : n;
        ms = (m == 0) ? 1 : m;
        odp = 1 << od;
        bitp = odp * ns;
        scale = (src == 1) ? ext_period : 1;
        case (eff_sel)
            0: tap = bitp;
            1: tap = 2 * bitp;
            2: tap = odp;
            default: tap = 4 * odp;
        endcase
        for (int i = 0; i < 3; i++) begin
            exp_b.push_back(bitp * 8 * scale); req_b.push_back(rb);
            exp_p.push_back(tap * ms * scale); req_p.push_back(rp);
        end
        guard = 0;
        while ((exp_b.size() > 0 || exp_p.size() > 0) && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 20000) begin
            check_eq(rb, "pulses missing", exp_b.size() + exp_p.size(), 0);
            exp_b.delete(); req_b.delete(); exp_p.delete(); req_p.delete();
        end
    endtask

    initial begin
        int cnt_b, cnt_p;
        // R10: outputs held low in reset, even with a rate of one per cycle
        repeat (5) @(negedge clk);
        check_eq("R10", "byte_en in reset", int'(byte_en), 0);
        check_eq("R10", "pix_en in reset", int'(pix_en), 0);
        @(negedge clk) rst = 1'b0;
        // R10 R4: tap 2 with E=0 gives a pixel pulse every cycle
        run_case(0, 1, 2, 1, 0, "R3", "R10", 2);
        // R1 R2 R3 R4 R5 at several patterns
        run_case(1, 2, 0, 3, 0, "R2", "R4", 0);
        run_case(2, 1, 2, 1, 0, "R1", "R4", 2);
        run_case(3, 5, 1, 2, 0, "R3", "R5", 1);
        run_case(2, 0, 3, 0, 0, "R2", "R5", 3);
        run_case(0, 15, 3, 15, 0, "R1", "R5", 3);
        // R9: output-divider tap pulses every cycle, so tap 0 is not applied
        run_case(0, 15, 0, 15, 0, "R3", "R9", 3);
        run_case(1, 3, 0, 2, 0, "R2", "R9", 0);
        // R7: external source, and reserved source codes count as internal
        run_case(1, 3, 0, 2, 1, "R7", "R7", 0);
        run_case(1, 3, 0, 2, 2, "R7", "R7", 0);
        run_case(1, 3, 0, 2, 0, "R7", "R7", 0);
        // R8: pixel divisor 2 -> 5 (12 -> 30 cycles), byte fixed at 48
        @(negedge clk); min_b = 1 << 30; min_p = 1 << 30;
        run_case(1, 3, 0, 5, 0, "R8", "R8", 0);
        check_ge("R8", "min pixel interval", min_p, 12);
        check_ge("R8", "min byte interval", min_b, 48);
        // R8: bit divisor 3 -> 1, byte 48 -> 16
        @(negedge clk); min_b = 1 << 30;
        run_case(1, 1, 0, 5, 0, "R8", "R5", 0);
        check_ge("R8", "min byte interval", min_b, 16);
        // R6: enable cleared silences both outputs
        apply_cfg(1, 1, 0, 5, 0, 1'b0);
        repeat (3) @(negedge clk);
        cnt_b = 0; cnt_p = 0;
        repeat (1000) begin
            @(negedge clk);
            cnt_b += int'(byte_en);
            cnt_p += int'(pix_en);
        end
        check_eq("R6", "byte pulses while disabled", cnt_b, 0);
        check_eq("R6", "pixel pulses while disabled", cnt_p, 0);
        // R6: pulses resume at configured periods
        last_b = -1; last_p = -1;
        run_case(1, 1, 0, 5, 0, "R6", "R6", 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule